// File: doc/BRIEF.md
# Banked Bit-Addressable Data Memory

This block is the 128-byte internal scratch memory of a small 8-bit controller core, together with the address logic that the core uses to reach it. One shared byte array is seen through several views. One view reaches the eight working registers of whichever of four banks is active. Other views reach any byte directly, or indirectly through one of the first two registers of the active bank. A bit view reaches the 128 single bits packed into bytes 20h to 2Fh. The last view is a stack that grows upward under an 8-bit stack pointer.

Each request carries an opcode on `op_i`, an address or register index, write data, a write bit and the bank-select pair. Writes land at the clock edge. Read results appear on registered outputs one cycle after the request and hold until the next read of the same kind. An access whose final byte or bit address is 80h or above falls outside this memory. It changes nothing, returns zero and raises a range flag.

Top module: `bank_bit_ram`

## Requirements
- R1: After reset `rdata_o`, `bit_o` and `range_err_o` are 0, the active bank is 0 and the stack pointer reads 07h.
- R2: Register read (op 1) and register write (op 2) reach byte {bank[1:0], addr_i[2:0]}; a read returns that byte on `rdata_o` in the following cycle.
- R3: Bank load (op 13) copies `bank_sel_i` into the active bank; no other request changes the bank.
- R4: Direct read (op 3) and direct write (op 4) reach byte `addr_i[6:0]` when `addr_i[7]` is 0.
- R5: Indirect read (op 5) and indirect write (op 6) reach the byte whose address is held in register R0 (`addr_i[0]`=0) or R1 (`addr_i[0]`=1) of the active bank.
- R6: Bit read (op 7) of bit address b returns bit b[2:0] of byte 20h + b[6:3] on `bit_o` in the following cycle.
- R7: Bit write (op 8) sets that bit to `bit_wdata_i` and leaves the other seven bits of the byte unchanged.
- R8: Push (op 9) first increments the stack pointer modulo 128 and then writes `wdata_i` at the new pointer, so 7Fh is followed by 00h.
- R9: Pop (op 10) returns the byte at the stack pointer and then decrements the pointer modulo 128, so 00h is followed by 7Fh.
- R10: Pointer read (op 11) returns the stack pointer on `rdata_o`; pointer write (op 12) loads `wdata_i[6:0]`, so bit 7 of the pointer is always 0.
- R11: A direct or bit access with `addr_i[7]`=1, or an indirect access whose pointer byte has bit 7 set, writes nothing, returns 0 and drives `range_err_o` high for one request. Every accepted request that does not fault clears `range_err_o`.
- R12: `rdata_o` changes only after ops 1, 3, 5, 10 and 11; `bit_o` changes only after op 7; with `req_i` low, or with op 0, all outputs hold except `range_err_o`, which op 0 clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| op_i | input | 4 | Operation code |
| addr_i | input | 8 | Byte address, bit address or register index |
| wdata_i | input | 8 | Write data for bytes, pushes and pointer load |
| bit_wdata_i | input | 1 | Value for a bit write |
| bank_sel_i | input | 2 | Bank number taken by a bank load |
| rdata_o | output | 8 | Registered byte result |
| bit_o | output | 1 | Registered bit result |
| range_err_o | output | 1 | Last request fell outside the memory |

## Verification
The assertions assume that `op_i` carries one of the fourteen defined codes whenever `req_i` is high. They also assume that reset is applied before the first request, because the byte array itself has no reset. The stimulus keeps to those codes throughout. Before any indirect, bit or stack access it fills every byte with a known pattern through direct writes, so that a pointer byte is never unknown. It then steers pointers and addresses across the 7Fh/80h edge on purpose, which exercises the out-of-range paths.

// File: rtl/bbram_pkg.sv
package bbram_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned REG_W    = 3;
  localparam int unsigned BANK_W   = 2;
  localparam int unsigned BIT_BASE = 32;
  localparam int unsigned SP_RESET = 7;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_REG_RD = 4'd1,
    OP_REG_WR = 4'd2,
    OP_DIR_RD = 4'd3,
    OP_DIR_WR = 4'd4,
    OP_IND_RD = 4'd5,
    OP_IND_WR = 4'd6,
    OP_BIT_RD = 4'd7,
    OP_BIT_WR = 4'd8,
    OP_PUSH   = 4'd9,
    OP_POP    = 4'd10,
    OP_SP_RD  = 4'd11,
    OP_SP_WR  = 4'd12,
    OP_BANK   = 4'd13
  } op_e;
endpackage

// File: rtl/bbram_store.sv
module bbram_store #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // array kept without reset; contents are defined by software
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/bbram_bit_lane.sv
module bbram_bit_lane #(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = $clog2(DW)
) (
  input  logic [DW-1:0] byte_i,
  input  logic [PW-1:0] pos_i,
  input  logic          bit_i,
  output logic          bit_o,
  output logic [DW-1:0] merged_o
);
  assign bit_o = byte_i[pos_i];

  for (genvar g = 0; g < DW; g++) begin : g_lane
    assign merged_o[g] = (pos_i == PW'(g)) ? bit_i : byte_i[g];
  end
endmodule

// File: rtl/bbram_stack_ptr.sv
module bbram_stack_ptr #(
  parameter int unsigned AW       = 7,
  parameter int unsigned DW       = 8,
  parameter int unsigned SP_RESET = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  output logic [AW-1:0] sp_o,
  output logic [DW-1:0] sp_byte_o
);
  logic [AW-1:0] sp_q, sp_d;

  always_comb begin
    sp_d = sp_q;
    if (ld_i)       sp_d = ld_val_i;
    else if (inc_i) sp_d = sp_q + AW'(1);
    else if (dec_i) sp_d = sp_q - AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= AW'(SP_RESET);
    else         sp_q <= sp_d;
  end

  assign sp_o      = sp_q;
  assign sp_byte_o = DW'(sp_q);

  assert_push_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i) |=> (sp_q == AW'($past(sp_q) + AW'(1))));
  assert_pop_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !ld_i && !inc_i) |=> (sp_q == AW'($past(sp_q) - AW'(1))));
  assert_sp_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (sp_q == $past(ld_val_i)));
  assert_sp_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !inc_i && !dec_i) |=> $stable(sp_q));
endmodule

// File: rtl/bbram_addr_gen.sv
module bbram_addr_gen
  import bbram_pkg::*;
#(
  parameter int unsigned AW       = 7,
  parameter int unsigned DW       = 8,
  parameter int unsigned RW       = 3,
  parameter int unsigned BW       = 2,
  parameter int unsigned BIT_BASE = 32
) (
  input  op_e           op_i,
  input  logic [DW-1:0] addr_i,
  input  logic [BW-1:0] bank_i,
  input  logic [AW-1:0] sp_i,
  input  logic [DW-1:0] ptr_i,
  output logic [AW-1:0] ptr_addr_o,
  output logic [AW-1:0] acc_addr_o,
  output logic          oor_o,
  output logic          wr_o,
  output logic          rd_o
);
  localparam int unsigned PW  = $clog2(DW);
  localparam int unsigned BYW = AW - PW;

  logic [AW-1:0] reg_addr, bit_byte_addr;

  assign reg_addr      = AW'({bank_i, addr_i[RW-1:0]});
  assign ptr_addr_o    = AW'({bank_i, {(RW-1){1'b0}}, addr_i[0]});
  assign bit_byte_addr = AW'(BIT_BASE) + AW'(addr_i[AW-1:PW]);

  always_comb begin
    acc_addr_o = addr_i[AW-1:0];
    oor_o      = 1'b0;
    wr_o       = 1'b0;
    rd_o       = 1'b0;
    unique case (op_i)
      OP_REG_RD: begin acc_addr_o = reg_addr; rd_o = 1'b1; end
      OP_REG_WR: begin acc_addr_o = reg_addr; wr_o = 1'b1; end
      OP_DIR_RD: begin oor_o = addr_i[DW-1]; rd_o = 1'b1; end
      OP_DIR_WR: begin oor_o = addr_i[DW-1]; wr_o = 1'b1; end
      OP_IND_RD: begin acc_addr_o = ptr_i[AW-1:0]; oor_o = ptr_i[DW-1]; rd_o = 1'b1; end
      OP_IND_WR: begin acc_addr_o = ptr_i[AW-1:0]; oor_o = ptr_i[DW-1]; wr_o = 1'b1; end
      OP_BIT_RD: begin acc_addr_o = bit_byte_addr; oor_o = addr_i[DW-1]; end
      OP_BIT_WR: begin acc_addr_o = bit_byte_addr; oor_o = addr_i[DW-1]; wr_o = 1'b1; end
      OP_PUSH:   begin acc_addr_o = sp_i + AW'(1); wr_o = 1'b1; end
      OP_POP:    begin acc_addr_o = sp_i; rd_o = 1'b1; end
      OP_SP_RD:  rd_o = 1'b1;
      default:   ;
    endcase
  end

  // bit field width must fit the bit-addressable window
  initial assert (BYW >= 4) else $error("bit window too narrow");
endmodule

// File: rtl/bank_bit_ram.sv
module bank_bit_ram
  import bbram_pkg::*;
#(
  parameter int unsigned AW = bbram_pkg::ADDR_W,
  parameter int unsigned DW = bbram_pkg::DATA_W,
  parameter int unsigned BW = bbram_pkg::BANK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          bit_wdata_i,
  input  logic [BW-1:0] bank_sel_i,
  output logic [DW-1:0] rdata_o,
  output logic          bit_o,
  output logic          range_err_o
);
  localparam int unsigned PW = $clog2(DW);

  op_e           op;
  logic [BW-1:0] bank_q;
  logic [AW-1:0] sp, ptr_addr, acc_addr;
  logic [DW-1:0] sp_byte, ptr_byte, acc_byte, merged, mem_wdata, rd_val;
  logic          acc_oor, acc_wr, acc_rd, lane_bit, mem_we;
  logic [DW-1:0] rdata_q;
  logic          bit_q, err_q;

  assign op = op_e'(op_i);

  bbram_addr_gen #(
    .AW(AW), .DW(DW), .RW(REG_W), .BW(BW), .BIT_BASE(BIT_BASE)
  ) i_addr_gen (
    .op_i(op), .addr_i(addr_i), .bank_i(bank_q), .sp_i(sp), .ptr_i(ptr_byte),
    .ptr_addr_o(ptr_addr), .acc_addr_o(acc_addr), .oor_o(acc_oor),
    .wr_o(acc_wr), .rd_o(acc_rd)
  );

  bbram_store #(.DW(DW), .AW(AW)) i_store (
    .clk_i(clk_i), .we_i(mem_we), .waddr_i(acc_addr), .wdata_i(mem_wdata),
    .raddr_a_i(ptr_addr), .rdata_a_o(ptr_byte),
    .raddr_b_i(acc_addr), .rdata_b_o(acc_byte)
  );

  bbram_bit_lane #(.DW(DW), .PW(PW)) i_bit_lane (
    .byte_i(acc_byte), .pos_i(addr_i[PW-1:0]), .bit_i(bit_wdata_i),
    .bit_o(lane_bit), .merged_o(merged)
  );

  bbram_stack_ptr #(.AW(AW), .DW(DW), .SP_RESET(SP_RESET)) i_stack_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .inc_i(req_i && op == OP_PUSH), .dec_i(req_i && op == OP_POP),
    .ld_i(req_i && op == OP_SP_WR), .ld_val_i(wdata_i[AW-1:0]),
    .sp_o(sp), .sp_byte_o(sp_byte)
  );

  assign mem_we    = req_i && acc_wr && !acc_oor;
  assign mem_wdata = (op == OP_BIT_WR) ? merged : wdata_i;
  assign rd_val    = (op == OP_SP_RD) ? sp_byte : (acc_oor ? '0 : acc_byte);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      bit_q   <= 1'b0;
      err_q   <= 1'b0;
      bank_q  <= '0;
    end else if (req_i) begin
      err_q <= acc_oor;
      if (acc_rd)            rdata_q <= rd_val;
      if (op == OP_BIT_RD)   bit_q   <= lane_bit && !acc_oor;
      if (op == OP_BANK)     bank_q  <= bank_sel_i;
    end
  end

  assign rdata_o     = rdata_q;
  assign bit_o       = bit_q;
  assign range_err_o = err_q;

  assert_bank_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && op == OP_BANK) |=> $stable(bank_q));
  assert_range_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && acc_oor) |=> range_err_o);
  assert_range_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && acc_oor && op != OP_SP_RD && acc_rd) |=> (rdata_o == '0));
  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || !acc_rd) |=> $stable(rdata_o));
  assert_bit_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && op == OP_BIT_RD) |=> $stable(bit_o));
endmodule

// File: tb/test_bank_bit_ram.sv
module test_bank_bit_ram;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  localparam logic [3:0] NOP = 0, REG_RD = 1, REG_WR = 2, DIR_RD = 3, DIR_WR = 4,
    IND_RD = 5, IND_WR = 6, BIT_RD = 7, BIT_WR = 8, PUSH = 9, POP = 10,
    SP_RD = 11, SP_WR = 12, BANK = 13;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] addr = '0, wd = '0;
  logic       bv = 1'b0;
  logic [1:0] bsel = '0;
  logic [7:0] rdata;
  logic       bit_out, err;

  int compared = 0, mismatched = 0;

  logic [7:0] m [128];
  int sp = 7, bank = 0;
  logic [7:0] e_rd = '0;
  logic       e_bit = 1'b0, e_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_bit_ram i_bank_bit_ram (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wd), .bit_wdata_i(bv), .bank_sel_i(bsel),
    .rdata_o(rdata), .bit_o(bit_out), .range_err_o(err)
  );

  function automatic string tag_of(logic [3:0] o);
    case (o)
      REG_RD, REG_WR: return "R2";
      BANK:           return "R3";
      DIR_RD, DIR_WR: return "R4";
      IND_RD, IND_WR: return "R5";
      BIT_RD:         return "R6";
      BIT_WR:         return "R7";
      PUSH:           return "R8";
      POP:            return "R9";
      SP_RD, SP_WR:   return "R10";
      default:        return "R12";
    endcase
  endfunction

  task automatic check(string t, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  task automatic compare(logic [3:0] o, logic r, string t);
    string tr, tb, te;
    tr = (t != "") ? t : ((r && (o inside {REG_RD, DIR_RD, IND_RD, POP, SP_RD})) ? tag_of(o) : "R12");
    tb = (t != "") ? t : ((r && o == BIT_RD) ? "R6" : "R12");
    te = (t != "") ? t : "R11";
    check(tr, "rdata", int'(rdata), int'(e_rd));
    check(tb, "bit", int'(bit_out), int'(e_bit));
    check(te, "range_err", int'(err), int'(e_err));
  endtask

  // behavioural reference, evaluated with pre-edge state
  task automatic model(logic [3:0] o, logic [7:0] a, logic [7:0] d, logic b, logic [1:0] s);
    int ad, p;
    e_err = 1'b0;
    case (o)
      REG_RD: e_rd = m[bank*8 + int'(a[2:0])];
      REG_WR: m[bank*8 + int'(a[2:0])] = d;
      DIR_RD: begin if (a >= 128) begin e_err = 1; e_rd = 0; end else e_rd = m[a]; end
      DIR_WR: begin if (a >= 128) e_err = 1; else m[a] = d; end
      IND_RD, IND_WR: begin
        p = int'(m[bank*8 + int'(a[0])]);
        if (p >= 128) begin e_err = 1; if (o == IND_RD) e_rd = 0; end
        else if (o == IND_RD) e_rd = m[p];
        else m[p] = d;
      end
      BIT_RD: begin
        if (a >= 128) begin e_err = 1; e_bit = 0; end
        else e_bit = m[32 + int'(a) / 8][int'(a) % 8];
      end
      BIT_WR: begin
        ad = 32 + int'(a) / 8;
        if (a >= 128) e_err = 1; else m[ad][int'(a) % 8] = b;
      end
      PUSH:  begin sp = (sp + 1) % 128; m[sp] = d; end
      POP:   begin e_rd = m[sp]; sp = (sp + 127) % 128; end
      SP_RD: e_rd = 8'(sp);
      SP_WR: sp = int'(d) % 128;
      BANK:  bank = int'(s);
      default: ;
    endcase
  endtask

  task automatic step(logic r, logic [3:0] o, logic [7:0] a, logic [7:0] d,
                      logic b, logic [1:0] s, string t);
    req = r; op = o; addr = a; wd = d; bv = b; bsel = s;
    if (r) model(o, a, d, b, s);
    @(posedge clk);
    @(negedge clk);
    compare(o, r, t);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    mismatched++;
    $display("FAIL all watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    compare(NOP, 1'b0, "R1");
    step(1, SP_RD, 0, 0, 0, 0, "R1");

    // fill every byte
    for (int i = 0; i < 128; i++) step(1, DIR_WR, 8'(i), 8'((i * 37 + 5) & 8'h7f), 0, 0, "R4");
    for (int i = 0; i < 128; i += 13) step(1, DIR_RD, 8'(i), 0, 0, 0, "R4");

    // register banks
    for (int b = 0; b < 4; b++) begin
      step(1, BANK, 0, 0, 0, 2'(b), "R3");
      for (int n = 0; n < 8; n++) step(1, REG_WR, 8'(n), 8'(8'hA0 + b * 8 + n), 0, 0, "R2");
      step(1, REG_RD, 8'(3), 0, 0, 0, "R2");
      step(1, DIR_RD, 8'(b * 8 + 5), 0, 0, 0, "R2");
    end
    step(1, BANK, 0, 0, 0, 2'd1, "R3");
    step(1, NOP, 0, 0, 0, 2'd3, "R12");
    step(1, REG_RD, 8'h07, 0, 0, 0, "R3");

    // indirect
    step(1, REG_WR, 8'h00, 8'h45, 0, 0, "R5");
    step(1, IND_WR, 8'h00, 8'h5A, 0, 0, "R5");
    step(1, DIR_RD, 8'h45, 0, 0, 0, "R5");
    step(1, REG_WR, 8'h01, 8'h90, 0, 0, "R11");
    step(1, IND_WR, 8'h01, 8'hEE, 0, 0, "R11");
    step(1, IND_RD, 8'h01, 0, 0, 0, "R11");
    step(1, DIR_RD, 8'h10, 0, 0, 0, "R11");

    // bits
    step(1, DIR_WR, 8'h2C, 8'h00, 0, 0, "R7");
    step(1, BIT_WR, 8'h63, 0, 1, 0, "R7");
    step(1, DIR_RD, 8'h2C, 0, 0, 0, "R7");
    step(1, DIR_WR, 8'h21, 8'hFF, 0, 0, "R7");
    step(1, BIT_WR, 8'h0E, 0, 0, 0, "R7");
    step(1, DIR_RD, 8'h21, 0, 0, 0, "R7");
    step(1, BIT_RD, 8'h0E, 0, 0, 0, "R6");
    step(1, BIT_RD, 8'h0F, 0, 0, 0, "R6");
    step(1, BIT_RD, 8'h7F, 0, 0, 0, "R6");
    step(1, BIT_WR, 8'h85, 0, 1, 0, "R11");
    step(1, BIT_RD, 8'h85, 0, 0, 0, "R11");
    step(1, DIR_RD, 8'h20, 0, 0, 0, "R11");
    step(1, DIR_WR, 8'h80, 8'h11, 0, 0, "R11");
    step(0, DIR_RD, 8'h33, 0, 0, 0, "R12");
    step(1, DIR_RD, 8'h00, 0, 0, 0, "R11");

    // stack wrap
    step(1, SP_WR, 0, 8'hFE, 0, 0, "R10");
    step(1, SP_RD, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 3; i++) step(1, PUSH, 0, 8'(8'hC0 + i), 0, 0, "R8");
    step(1, SP_RD, 0, 0, 0, 0, "R8");
    step(1, DIR_RD, 8'h00, 0, 0, 0, "R8");
    for (int i = 0; i < 4; i++) step(1, POP, 0, 0, 0, 0, "R9");
    step(1, SP_RD, 0, 0, 0, 0, "R9");

    // mixed traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom_range(0, 7) != 0), 4'($urandom_range(0, 13)), 8'($urandom),
           8'($urandom), 1'($urandom), 2'($urandom), "");

    finish_run();
  end
endmodule